// File: doc/BRIEF.md
# Software Interrupt Entry Sequencer

This block carries out the entry into a software interrupt for an 8/16-bit accumulator-style processor. Decode raises `start` for a break or a coprocessor trap opcode and marks which one with `cop_sel`. The sequencer captures the processor context presented on its inputs: program counter, program bank, packed status byte, stack pointer and the emulation/native mode bit. It then drives a byte-wide memory port one access at a time. The first access fetches the signature byte that follows the opcode, and that byte is discarded. Next come the stack pushes. Last come the two reads of a 16-bit handler vector.

The context to save depends on the mode bit. Native mode pushes the program bank before the return address, and emulation mode leaves it out. In emulation mode the stack is also held inside page one. Each mode has its own pair of vectors, one for break and one for the coprocessor trap. When the high vector byte arrives, the block presents the new program counter and stack pointer. It forces the program bank to zero and gives a status byte with interrupts disabled and decimal mode cleared. A one-cycle `done` pulse marks these values as valid.

Top module: `swi_entry_seq`

## Requirements
- R1: After a synchronous reset, or a reset in the middle of a sequence, `busy`, `done` and `mem_req` are 0 and `pc_out`, `bank_out`, `stat_out` are 0.
- R2: The first memory access after `start` is a read at {bank_in, pc_in}. The byte it returns is discarded. The return address pushed later is pc_in+1 (16-bit wrap, bank unchanged).
- R3: Native mode (emu_mode=0) writes, in this order: bank_in, return address bits 15:8, return address bits 7:0, stat_in unchanged. Emulation mode (emu_mode=1) writes the same sequence without the bank byte.
- R4: Every push writes to {8'h00, sp} and then decrements sp by one. In native mode the full 16-bit pointer wraps from 0000 to FFFF.
- R5: In emulation mode the stack address high byte is forced to 8'h01 whatever sp_in[15:8] holds, and only the low byte decrements (0100 is followed by 01FF).
- R6: The vector address V is FFE6 for native break, FFE4 for native coprocessor trap, FFFE for emulation break and FFF4 for emulation coprocessor trap.
- R7: After the pushes, two reads take place in bank 0: the low byte at V, then the high byte at V+1. At `done`, pc_out = {high, low} and bank_out = 0.
- R8: At `done`, stat_out equals stat_in with bit 2 (interrupt disable) set and bit 3 (decimal) cleared. All other bits are kept.
- R9: `done` is high for exactly one cycle, in the cycle after the high vector byte is accepted. `busy` is high from the cycle after `start` is taken until that cycle, and is low while `done` is high. sp_out then holds the final stack pointer.
- R10: `start` is ignored while `busy` is high. Inputs that change during a sequence do not affect it.
- R11: An access completes only in a cycle where `mem_req` and `mem_ready` are both high. While `mem_ready` is low, the address, direction and write data are held and the sequence does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an entry sequence (taken when not busy) |
| cop_sel | input | 1 | 1 = coprocessor trap, 0 = break |
| emu_mode | input | 1 | 1 = emulation mode, 0 = native mode |
| pc_in | input | 16 | Address of the signature byte |
| bank_in | input | 8 | Current program bank |
| stat_in | input | 8 | Packed status byte |
| sp_in | input | 16 | Current stack pointer |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse, outputs valid |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 24 | Access address {bank, offset} |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid in the accepting cycle |
| mem_ready | input | 1 | Access accepted this cycle |
| pc_out | output | 16 | Handler program counter |
| bank_out | output | 8 | New program bank (zero) |
| stat_out | output | 8 | Status after entry |
| sp_out | output | 16 | Stack pointer after the pushes |

## Verification
The bench builds the block with its default vector parameters, so all four mode and source combinations reach their own vector address. It checks the whole access trace of each case against values the bench computes itself. The table cases place the stack pointer at 0002, 0100 and 0101, and one case has a non-page-one high byte in emulation mode. This brings both the native 16-bit wrap and the forced page-one wrap within reach, and a program counter of FFFF exercises the return address wrap. Directed runs add a memory that stalls every third cycle, a second `start` with changed inputs during a run, and a reset in the middle of a sequence.

// File: rtl/swi_pkg.sv
package swi_pkg;

    localparam int DATA_W = 8;
    localparam int PC_W   = 16;
    localparam int BANK_W = 8;
    localparam int SP_W   = 16;
    localparam int ADDR_W = BANK_W + PC_W;

    localparam int IRQ_OFF_BIT = 2;
    localparam int DEC_BIT     = 3;

    localparam logic [7:0] EMU_STACK_PAGE = 8'h01;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SIG,
        ST_BANK,
        ST_RETH,
        ST_RETL,
        ST_STAT,
        ST_VLO,
        ST_VHI
    } seq_st_e;

    typedef struct packed {
        logic              emu;
        logic              cop;
        logic [PC_W-1:0]   pc;
        logic [BANK_W-1:0] bank;
        logic [DATA_W-1:0] stat;
    } ctx_t;

    function automatic logic [ADDR_W-1:0] push_addr(input logic emu, input logic [SP_W-1:0] sp);
        if (emu)
            push_addr = {{BANK_W{1'b0}}, EMU_STACK_PAGE, sp[7:0]};
        else
            push_addr = {{BANK_W{1'b0}}, sp};
    endfunction

    function automatic logic [SP_W-1:0] sp_after_push(input logic emu, input logic [SP_W-1:0] sp);
        if (emu)
            sp_after_push = {EMU_STACK_PAGE, sp[7:0] - 8'd1};
        else
            sp_after_push = sp - 1'b1;
    endfunction

    function automatic logic [DATA_W-1:0] entry_status(input logic [DATA_W-1:0] s);
        logic [DATA_W-1:0] r;
        r = s;
        r[IRQ_OFF_BIT] = 1'b1;
        r[DEC_BIT]     = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/swi_vec_sel.sv
module swi_vec_sel
    import swi_pkg::*;
#(
    parameter logic [PC_W-1:0] VEC_NAT_BRK = 16'hFFE6,
    parameter logic [PC_W-1:0] VEC_NAT_COP = 16'hFFE4,
    parameter logic [PC_W-1:0] VEC_EMU_BRK = 16'hFFFE,
    parameter logic [PC_W-1:0] VEC_EMU_COP = 16'hFFF4
) (
    input  logic            emu,
    input  logic            cop,
    output logic [PC_W-1:0] vec_lo_addr,
    output logic [PC_W-1:0] vec_hi_addr
);
    localparam int N_VEC = 4;
    logic [PC_W-1:0] table_q [N_VEC];

    assign table_q[0] = VEC_NAT_BRK;
    assign table_q[1] = VEC_NAT_COP;
    assign table_q[2] = VEC_EMU_BRK;
    assign table_q[3] = VEC_EMU_COP;

    always_comb begin
        vec_lo_addr = table_q[{emu, cop}];
        vec_hi_addr = vec_lo_addr + 1'b1;
    end
endmodule

// File: rtl/swi_stack_ptr.sv
module swi_stack_ptr
    import swi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [SP_W-1:0]   load_val,
    input  logic              dec,
    input  logic              emu,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [SP_W-1:0]   sp
);
    logic [SP_W-1:0] sp_q;

    always_ff @(posedge clk) begin
        if (rst)
            sp_q <= '0;
        else if (load)
            sp_q <= load_val;
        else if (dec)
            sp_q <= sp_after_push(emu, sp_q);
    end

    assign wr_addr = push_addr(emu, sp_q);
    assign sp      = sp_q;

    // R5: an emulation-mode push leaves the pointer inside page one
    a_r5_emu_page: assert property (@(posedge clk) disable iff (rst)
        (dec && !load && emu) |=> (sp_q[15:8] == EMU_STACK_PAGE));

    // R4: a native push moves the pointer down by exactly one
    a_r4_native_step: assert property (@(posedge clk) disable iff (rst)
        (dec && !load && !emu) |=> (sp_q == $past(sp_q) - 16'd1));
endmodule

// File: rtl/swi_push_mux.sv
module swi_push_mux
    import swi_pkg::*;
(
    input  seq_st_e           st,
    input  ctx_t              ctx,
    output logic              is_push,
    output logic [DATA_W-1:0] push_byte
);
    always_comb begin
        is_push   = 1'b1;
        push_byte = '0;
        unique case (st)
            ST_BANK: push_byte = ctx.bank;
            ST_RETH: push_byte = ctx.pc[15:8];
            ST_RETL: push_byte = ctx.pc[7:0];
            ST_STAT: push_byte = ctx.stat;
            default: is_push   = 1'b0;
        endcase
    end
endmodule

// File: rtl/swi_entry_seq.sv
module swi_entry_seq
    import swi_pkg::*;
#(
    parameter logic [15:0] VEC_NAT_BRK = 16'hFFE6,
    parameter logic [15:0] VEC_NAT_COP = 16'hFFE4,
    parameter logic [15:0] VEC_EMU_BRK = 16'hFFFE,
    parameter logic [15:0] VEC_EMU_COP = 16'hFFF4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        cop_sel,
    input  logic        emu_mode,
    input  logic [15:0] pc_in,
    input  logic [7:0]  bank_in,
    input  logic [7:0]  stat_in,
    input  logic [15:0] sp_in,
    output logic        busy,
    output logic        done,
    output logic        mem_req,
    output logic        mem_we,
    output logic [23:0] mem_addr,
    output logic [7:0]  mem_wdata,
    input  logic [7:0]  mem_rdata,
    input  logic        mem_ready,
    output logic [15:0] pc_out,
    output logic [7:0]  bank_out,
    output logic [7:0]  stat_out,
    output logic [15:0] sp_out
);
    seq_st_e            st_q;
    ctx_t               ctx_q;
    logic [DATA_W-1:0]  vlo_q;
    logic               take;
    logic               ack;
    logic               is_push;
    logic [DATA_W-1:0]  push_byte;
    logic [ADDR_W-1:0]  stk_addr;
    logic [PC_W-1:0]    vlo_addr;
    logic [PC_W-1:0]    vhi_addr;

    assign busy = (st_q != ST_IDLE);
    assign take = start && !busy;
    assign ack  = mem_req && mem_ready;

    swi_vec_sel #(
        .VEC_NAT_BRK(VEC_NAT_BRK),
        .VEC_NAT_COP(VEC_NAT_COP),
        .VEC_EMU_BRK(VEC_EMU_BRK),
        .VEC_EMU_COP(VEC_EMU_COP)
    ) u_vec (
        .emu         (ctx_q.emu),
        .cop         (ctx_q.cop),
        .vec_lo_addr (vlo_addr),
        .vec_hi_addr (vhi_addr)
    );

    swi_stack_ptr u_sp (
        .clk      (clk),
        .rst      (rst),
        .load     (take),
        .load_val (sp_in),
        .dec      (ack && is_push),
        .emu      (ctx_q.emu),
        .wr_addr  (stk_addr),
        .sp       (sp_out)
    );

    swi_push_mux u_mux (
        .st        (st_q),
        .ctx       (ctx_q),
        .is_push   (is_push),
        .push_byte (push_byte)
    );

    always_comb begin
        mem_req   = busy;
        mem_we    = is_push;
        mem_wdata = is_push ? push_byte : '0;
        unique case (st_q)
            ST_SIG:  mem_addr = {ctx_q.bank, ctx_q.pc};
            ST_VLO:  mem_addr = {{BANK_W{1'b0}}, vlo_addr};
            ST_VHI:  mem_addr = {{BANK_W{1'b0}}, vhi_addr};
            default: mem_addr = is_push ? stk_addr : '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            ctx_q    <= '0;
            vlo_q    <= '0;
            done     <= 1'b0;
            pc_out   <= '0;
            bank_out <= '0;
            stat_out <= '0;
        end else begin
            done <= 1'b0;
            unique case (st_q)
                ST_IDLE: if (take) begin
                    ctx_q <= '{emu: emu_mode, cop: cop_sel, pc: pc_in,
                               bank: bank_in, stat: stat_in};
                    st_q  <= ST_SIG;
                end
                ST_SIG: if (ack) begin
                    ctx_q.pc <= ctx_q.pc + 1'b1;
                    st_q     <= ctx_q.emu ? ST_RETH : ST_BANK;
                end
                ST_BANK: if (ack) st_q <= ST_RETH;
                ST_RETH: if (ack) st_q <= ST_RETL;
                ST_RETL: if (ack) st_q <= ST_STAT;
                ST_STAT: if (ack) st_q <= ST_VLO;
                ST_VLO: if (ack) begin
                    vlo_q <= mem_rdata;
                    st_q  <= ST_VHI;
                end
                ST_VHI: if (ack) begin
                    pc_out   <= {mem_rdata, vlo_q};
                    bank_out <= '0;
                    stat_out <= entry_status(ctx_q.stat);
                    done     <= 1'b1;
                    st_q     <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // R11: a stalled access holds its address, direction and data
    a_r11_stall_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R9: done lasts exactly one cycle
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9: the block is idle while done is shown
    a_r9_idle_on_done: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R2: a sequence opens with a read
    a_r2_first_read: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (mem_req && !mem_we));

    // R7: handler runs in bank zero
    a_r7_bank_zero: assert property (@(posedge clk) disable iff (rst)
        done |-> (bank_out == 8'h00));

    // R8: interrupts disabled, decimal cleared on entry
    a_r8_flags: assert property (@(posedge clk) disable iff (rst)
        done |-> (stat_out[2] && !stat_out[3]));

    // R10: a second start during a run does not restart it
    a_r10_no_restart: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !ack) |=> $stable(mem_addr));
endmodule

// File: tb/swi_entry_seq_tb.sv
`timescale 1ns/1ps
module swi_entry_seq_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic        cop_sel;
    logic        emu_mode;
    logic [15:0] pc_in;
    logic [7:0]  bank_in;
    logic [7:0]  stat_in;
    logic [15:0] sp_in;
    logic        busy, done, mem_req, mem_we, mem_ready;
    logic [23:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;
    logic [15:0] pc_out, sp_out;
    logic [7:0]  bank_out, stat_out;

    int checks   = 0;
    int failures = 0;

    always #2 clk = ~clk;

    swi_entry_seq u_dut (
        .clk(clk), .rst(rst), .start(start), .cop_sel(cop_sel), .emu_mode(emu_mode),
        .pc_in(pc_in), .bank_in(bank_in), .stat_in(stat_in), .sp_in(sp_in),
        .busy(busy), .done(done), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ready(mem_ready), .pc_out(pc_out), .bank_out(bank_out),
        .stat_out(stat_out), .sp_out(sp_out)
    );

    function automatic logic [7:0] mem_byte(input logic [23:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ a[23:16] ^ 8'h3C;
    endfunction

    assign mem_rdata = mem_byte(mem_addr);

    logic [23:0] lg_addr [0:15];
    logic        lg_we   [0:15];
    logic [7:0]  lg_data [0:15];
    int          lg_n;

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // row = {emu, cop, pc, bank, stat, sp}
    localparam int N_ROWS = 6;
    localparam logic [49:0] ROWS [N_ROWS] = '{
        {1'b0, 1'b0, 16'h1234, 8'h7E, 8'h08, 16'h1FF0},
        {1'b1, 1'b0, 16'h8000, 8'h00, 8'h30, 16'h01FF},
        {1'b0, 1'b1, 16'hFFFF, 8'h12, 8'hFF, 16'h0002},
        {1'b1, 1'b1, 16'h0100, 8'h00, 8'h00, 16'h3402},
        {1'b0, 1'b1, 16'h4000, 8'h80, 8'h04, 16'h0100},
        {1'b1, 1'b0, 16'hABCD, 8'h05, 8'hC3, 16'h0101}
    };

    task automatic run_case(input logic [49:0] row, input bit stall, input bit poke);
        logic        e, c;
        logic [15:0] p, s, v, rp, sp_x;
        logic [7:0]  b, st;
        logic [23:0] ea [0:7];
        logic        ew [0:7];
        logic [7:0]  ed [0:7];
        int          n, cyc;
        bit          seen, busy_ok;
        {e, c, p, b, st, s} = row;

        rp = p + 16'd1;
        v  = e ? (c ? 16'hFFF4 : 16'hFFFE) : (c ? 16'hFFE4 : 16'hFFE6);
        n = 0;
        ea[n] = {b, p}; ew[n] = 1'b0; ed[n] = 8'h00; n++;
        sp_x = e ? {8'h01, s[7:0]} : s;
        if (!e) begin ea[n] = {8'h00, sp_x}; ew[n] = 1'b1; ed[n] = b; n++;
            sp_x = sp_x - 16'd1; end
        ea[n] = {8'h00, sp_x}; ew[n] = 1'b1; ed[n] = rp[15:8]; n++;
        sp_x = e ? {8'h01, sp_x[7:0] - 8'd1} : sp_x - 16'd1;
        ea[n] = {8'h00, sp_x}; ew[n] = 1'b1; ed[n] = rp[7:0]; n++;
        sp_x = e ? {8'h01, sp_x[7:0] - 8'd1} : sp_x - 16'd1;
        ea[n] = {8'h00, sp_x}; ew[n] = 1'b1; ed[n] = st; n++;
        sp_x = e ? {8'h01, sp_x[7:0] - 8'd1} : sp_x - 16'd1;
        ea[n] = {8'h00, v}; ew[n] = 1'b0; ed[n] = 8'h00; n++;
        ea[n] = {8'h00, v + 16'd1}; ew[n] = 1'b0; ed[n] = 8'h00; n++;

        @(negedge clk);
        emu_mode = e; cop_sel = c; pc_in = p; bank_in = b; stat_in = st; sp_in = s;
        start = 1'b1; mem_ready = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lg_n = 0; cyc = 0; seen = 0; busy_ok = 1;
        while (!seen && cyc < 100) begin
            mem_ready = stall ? (cyc % 3 != 1) : 1'b1;
            if (poke && cyc == 3) begin
                start = 1'b1; pc_in = 16'h5555; emu_mode = ~e; sp_in = 16'h7777;
            end else begin
                start = 1'b0;
            end
            #1;
            if (done) seen = 1;
            else begin
                if (!busy) busy_ok = 0;
                if (mem_req && mem_ready && lg_n < 16) begin
                    lg_addr[lg_n] = mem_addr; lg_we[lg_n] = mem_we;
                    lg_data[lg_n] = mem_wdata; lg_n++;
                end
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        chk(seen, "R9 watchdog done seen", 32'(cyc), 32'd100);
        chk(busy_ok, "R9 busy held until done", 32'(busy_ok), 32'd1);
        chk(lg_n == n, "R3 access count", 32'(lg_n), 32'(n));
        for (int i = 0; i < n && i < lg_n; i++) begin
            chk(lg_addr[i] == ea[i], i == 0 ? "R2 signature read addr" :
                (ew[i] ? (e ? "R5 push addr" : "R4 push addr") : "R6 vector addr"),
                32'(lg_addr[i]), 32'(ea[i]));
            chk(lg_we[i] == ew[i], "R3 access direction", 32'(lg_we[i]), 32'(ew[i]));
            if (ew[i]) chk(lg_data[i] == ed[i], "R3 push data", 32'(lg_data[i]), 32'(ed[i]));
        end
        #1;
        chk(!busy, "R9 idle during done", 32'(busy), 32'd0);
        chk(pc_out == {mem_byte({8'h00, v + 16'd1}), mem_byte({8'h00, v})}, "R7 pc_out",
            32'(pc_out), 32'({mem_byte({8'h00, v + 16'd1}), mem_byte({8'h00, v})}));
        chk(bank_out == 8'h00, "R7 bank_out", 32'(bank_out), 32'd0);
        chk(stat_out == ((st | 8'h04) & 8'hF7), "R8 stat_out", 32'(stat_out),
            32'((st | 8'h04) & 8'hF7));
        chk(sp_out == sp_x, "R9 sp_out", 32'(sp_out), 32'(sp_x));
        @(negedge clk);
        #1;
        chk(!done, "R9 done single cycle", 32'(done), 32'd0);
        chk(!busy && !mem_req, "R10 no second run", 32'({busy, mem_req}), 32'd0);
    endtask

    initial begin
        #400000;
        failures++;
        $display("FAIL watchdog expired actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1; start = 1'b0; cop_sel = 1'b0; emu_mode = 1'b0; pc_in = '0;
        bank_in = '0; stat_in = '0; sp_in = '0; mem_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        chk(!busy && !done && !mem_req, "R1 reset control", 32'({busy, done, mem_req}), 32'd0);
        chk(pc_out == 0 && bank_out == 0 && stat_out == 0, "R1 reset outputs",
            32'({pc_out, bank_out, stat_out}), 32'd0);

        for (int r = 0; r < N_ROWS; r++) run_case(ROWS[r], 1'b0, 1'b0);

        // R11: stalling memory
        run_case(ROWS[0], 1'b1, 1'b0);
        run_case(ROWS[5], 1'b1, 1'b0);
        // R10: start and inputs changed while busy
        run_case(ROWS[1], 1'b0, 1'b1);
        run_case(ROWS[2], 1'b1, 1'b1);

        // R1: reset in the middle of a sequence
        @(negedge clk);
        emu_mode = 1'b0; pc_in = 16'h2222; sp_in = 16'h0500; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(!busy && !mem_req && !done, "R1 mid-run reset", 32'({busy, mem_req, done}), 32'd0);
        chk(pc_out == 0 && stat_out == 0, "R1 mid-run reset outputs",
            32'({pc_out, stat_out}), 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule